// File: doc/BRIEF.md
# Cache Line Refill Controller with Early Word Delivery

This block runs the refill of one cache line after a miss. It accepts a miss, sends one request to the next memory level, and writes each returned word into a line buffer while it arrives. The word the processor missed on is handed to the processor in the same cycle that it arrives from memory, so the pipeline can restart before the rest of the line is present.

Two fetch orders are offered, chosen per miss. In wrapped order, memory returns the missed word first and then the following words, wrapping at the end of the line. In ascending order, memory returns the line from word 0 upward, and the missed word is still handed over the moment it appears. While the refill runs, processor accesses that target the refilling line are answered at once if their word is already in the buffer. Otherwise they are told to stall, and they are served in the cycle that word arrives. Tag lookup, victim choice and the memory device are handled outside this block.

The default line holds 8 words of 32 bits. Memory returns at most one word per cycle, with a valid strobe and a latency the block does not know in advance.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset the block is idle: `miss_ready`=1, `mem_req_valid`=0, `line_valid`=0 and `fill_mask`=0. No access gets `acc_hit` or `acc_stall`.
- R2: A miss is accepted on a clock edge where `miss_valid` and `miss_ready` are both 1. From the next cycle, `mem_req_valid` is 1 and stays 1, with `mem_req_line`, `mem_req_start` and `mem_req_wrap` stable, until an edge where `mem_req_ready` is 1. `mem_req_start` equals the missed word index when `miss_crit_first`=1 was sampled, and 0 otherwise.
- R3: In wrapped mode (`miss_crit_first`=1 at acceptance), the k-th returned word (k=0..7) is written with `fill_idx`=(c+k) mod 8, where c is the missed word index. `fill_we` is 1 in exactly the cycles where `mem_rsp_valid` is 1 during the fill. Bit i of `fill_mask` is 1 once word i has been written.
- R4: In ascending mode (`miss_crit_first`=0 at acceptance), the k-th returned word is written with `fill_idx`=k.
- R5: `crit_valid` is 1, with `crit_data` equal to `mem_rsp_data`, in exactly the one cycle of the refill in which the missed word arrives. The path from `mem_rsp_data` to `crit_data` is combinational.
- R6: An access (`acc_valid`=1) to the refilling line, or to the completed line, sees `acc_hit`=1 and `acc_data` equal to word `acc_word` in the same cycle if that word has arrived or is arriving in that cycle. During a refill it otherwise sees `acc_stall`=1. An access to any other line sees neither signal.
- R7: `line_valid` is 0 from acceptance until the eighth word is written. It becomes 1, and `miss_ready` returns to 1, in the cycle after that write.
- R8: While a refill is pending, `miss_ready` is 0. `miss_valid`, `miss_line`, `miss_word` and `miss_crit_first` then have no effect on the request or the fill. A `mem_rsp_valid` outside the fill phase writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_line | input | LINE_AW | Line address of the miss |
| miss_word | input | IDX_W | Index of the missed word within the line |
| miss_crit_first | input | 1 | 1 = wrapped order starting at the missed word, 0 = ascending order |
| miss_ready | output | 1 | Block is idle and can take a miss |
| mem_req_valid | output | 1 | Line request to memory is pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_line | output | LINE_AW | Requested line address |
| mem_req_start | output | IDX_W | First word memory must return |
| mem_req_wrap | output | 1 | Memory must wrap at the line end |
| mem_rsp_valid | input | 1 | A returned word is present |
| mem_rsp_data | input | WORD_W | Returned word |
| fill_we | output | 1 | Write strobe for the line storage |
| fill_idx | output | IDX_W | Word index being written |
| fill_data | output | WORD_W | Word being written |
| fill_mask | output | LINE_WORDS | One bit per word that has arrived |
| line_valid | output | 1 | Refilled line is complete |
| crit_valid | output | 1 | Missed word is delivered this cycle |
| crit_data | output | WORD_W | Missed word |
| acc_valid | input | 1 | Processor access presented |
| acc_line | input | LINE_AW | Line address of the access |
| acc_word | input | IDX_W | Word index of the access |
| acc_hit | output | 1 | Access is served this cycle |
| acc_stall | output | 1 | Access must wait for its word |
| acc_data | output | WORD_W | Data for a served access |

## Verification
A wrong word counter or start index shows at `fill_idx` on the very first returned word of a refill. In wrapped mode it also shows at `crit_valid`, which must rise on that first word. A corrupt arrival mask shows in the same cycle: an access to a word not yet fetched reports `acc_hit`, or one to a word already fetched reports `acc_stall`. A bad completion count shows one cycle after the eighth word, as `line_valid` or `miss_ready` at the wrong level. The bench sweeps every missed-word index in both orders, for two lines and several latencies and bubble patterns. It moves the probed access word every cycle, so every mask bit is seen both clear and set.

// File: rtl/refill_pkg.sv
package refill_pkg;
    typedef enum logic [1:0] {
        FILL_IDLE = 2'd0,
        FILL_REQ  = 2'd1,
        FILL_DATA = 2'd2
    } fill_state_e;
endpackage

// File: rtl/refill_order.sv
module refill_order #(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic             wrap,
    input  logic [IDX_W-1:0] start,
    input  logic [IDX_W-1:0] count,
    output logic [IDX_W-1:0] idx
);
    localparam bit IS_POW2 = (LINE_WORDS & (LINE_WORDS - 1)) == 0;

    logic [IDX_W-1:0] wrapped;

    generate
        if (IS_POW2) begin : g_pow2
            always_comb wrapped = start + count;
        end else begin : g_mod
            logic [IDX_W:0] sum;
            always_comb begin
                sum = {1'b0, start} + {1'b0, count};
                if (sum >= (IDX_W+1)'(LINE_WORDS))
                    sum = sum - (IDX_W+1)'(LINE_WORDS);
                wrapped = sum[IDX_W-1:0];
            end
        end
    endgenerate

    always_comb idx = wrap ? wrapped : count;
endmodule

// File: rtl/refill_arrivals.sv
module refill_arrivals #(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    output logic [LINE_WORDS-1:0] mask
);
    logic [LINE_WORDS-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (clr)
            mask_d = '0;
        else if (set_en)
            mask_d[set_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask = mask_q;
endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] word_q [LINE_WORDS];

    generate
        for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
            logic [WORD_W-1:0] word_d;
            always_comb word_d = (we && widx == IDX_W'(i)) ? wdata : word_q[i];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) word_q[i] <= '0;
                else        word_q[i] <= word_d;
            end
        end
    endgenerate

    assign rdata = word_q[ridx];
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl
    import refill_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int LINE_AW    = 26,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  miss_valid,
    input  logic [LINE_AW-1:0]    miss_line,
    input  logic [IDX_W-1:0]      miss_word,
    input  logic                  miss_crit_first,
    output logic                  miss_ready,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [LINE_AW-1:0]    mem_req_line,
    output logic [IDX_W-1:0]      mem_req_start,
    output logic                  mem_req_wrap,
    input  logic                  mem_rsp_valid,
    input  logic [WORD_W-1:0]     mem_rsp_data,
    output logic                  fill_we,
    output logic [IDX_W-1:0]      fill_idx,
    output logic [WORD_W-1:0]     fill_data,
    output logic [LINE_WORDS-1:0] fill_mask,
    output logic                  line_valid,
    output logic                  crit_valid,
    output logic [WORD_W-1:0]     crit_data,
    input  logic                  acc_valid,
    input  logic [LINE_AW-1:0]    acc_line,
    input  logic [IDX_W-1:0]      acc_word,
    output logic                  acc_hit,
    output logic                  acc_stall,
    output logic [WORD_W-1:0]     acc_data
);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LINE_WORDS - 1);

    typedef struct packed {
        fill_state_e        st;
        logic               wrap;
        logic [LINE_AW-1:0] line;
        logic [IDX_W-1:0]   crit;
        logic [CNT_W-1:0]   cnt;
        logic               lvalid;
    } refill_state_t;

    refill_state_t s_d, s_q;

    logic              accept;
    logic              in_fill;
    logic [IDX_W-1:0]  order_idx;
    logic [WORD_W-1:0] buf_rdata;
    logic              line_match;
    logic              word_here;

    always_comb begin
        accept  = (s_q.st == FILL_IDLE) && miss_valid;
        in_fill = (s_q.st == FILL_DATA) && mem_rsp_valid;
    end

    refill_order #(.LINE_WORDS(LINE_WORDS)) u_order (
        .wrap  (s_q.wrap),
        .start (s_q.crit),
        .count (s_q.cnt[IDX_W-1:0]),
        .idx   (order_idx)
    );

    refill_arrivals #(.LINE_WORDS(LINE_WORDS)) u_arrivals (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .set_en  (in_fill),
        .set_idx (order_idx),
        .mask    (fill_mask)
    );

    refill_linebuf #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_linebuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (in_fill),
        .widx  (order_idx),
        .wdata (mem_rsp_data),
        .ridx  (acc_word),
        .rdata (buf_rdata)
    );

    // next-state computation
    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            FILL_IDLE: begin
                if (miss_valid) begin
                    s_d.st     = FILL_REQ;
                    s_d.wrap   = miss_crit_first;
                    s_d.line   = miss_line;
                    s_d.crit   = miss_word;
                    s_d.cnt    = '0;
                    s_d.lvalid = 1'b0;
                end
            end
            FILL_REQ: begin
                if (mem_req_ready)
                    s_d.st = FILL_DATA;
            end
            FILL_DATA: begin
                if (mem_rsp_valid) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == LAST_CNT) begin
                        s_d.st     = FILL_IDLE;
                        s_d.lvalid = 1'b1;
                    end
                end
            end
            default: s_d.st = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: FILL_IDLE, wrap: 1'b0, line: '0, crit: '0,
                     cnt: '0, lvalid: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // outputs
    always_comb begin
        miss_ready    = (s_q.st == FILL_IDLE);
        mem_req_valid = (s_q.st == FILL_REQ);
        mem_req_line  = s_q.line;
        mem_req_wrap  = s_q.wrap;
        mem_req_start = s_q.wrap ? s_q.crit : '0;

        fill_we    = in_fill;
        fill_idx   = order_idx;
        fill_data  = mem_rsp_data;
        line_valid = s_q.lvalid;

        crit_valid = in_fill && (order_idx == s_q.crit);
        crit_data  = mem_rsp_data;

        line_match = (acc_line == s_q.line) && ((s_q.st != FILL_IDLE) || s_q.lvalid);
        word_here  = fill_mask[acc_word] || (in_fill && order_idx == acc_word);
        acc_hit    = acc_valid && line_match && word_here;
        acc_stall  = acc_valid && line_match && !word_here && (s_q.st != FILL_IDLE);
        acc_data   = fill_mask[acc_word] ? buf_rdata : mem_rsp_data;
    end
endmodule

// File: rtl/line_refill_checker.sv
module line_refill_checker #(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  miss_ready,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic [IDX_W-1:0]      mem_req_start,
    input logic                  mem_req_wrap,
    input logic                  fill_we,
    input logic [IDX_W-1:0]      fill_idx,
    input logic [LINE_WORDS-1:0] fill_mask,
    input logic                  line_valid,
    input logic                  crit_valid,
    input logic                  acc_hit,
    input logic                  acc_stall
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_start) && $stable(mem_req_wrap));

    // R3
    no_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |-> !fill_mask[fill_idx]);

    // R3
    wrap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crit_valid && mem_req_wrap |-> fill_mask == '0);

    // R7
    full_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> &fill_mask);

    // R8
    busy_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_ready |-> !line_valid);

    // R6
    hit_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_hit, acc_stall}));
endmodule

bind line_refill_ctrl line_refill_checker #(.LINE_WORDS(LINE_WORDS)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_ready    (miss_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_start (mem_req_start),
    .mem_req_wrap  (mem_req_wrap),
    .fill_we       (fill_we),
    .fill_idx      (fill_idx),
    .fill_mask     (fill_mask),
    .line_valid    (line_valid),
    .crit_valid    (crit_valid),
    .acc_hit       (acc_hit),
    .acc_stall     (acc_stall)
);

// File: tb/line_refill_ctrl_bench.sv
module line_refill_ctrl_bench;
    localparam int WORD_W = 32;
    localparam int LINE_WORDS = 8;
    localparam int LINE_AW = 26;
    localparam int IDX_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0;
    logic [LINE_AW-1:0] miss_line = '0;
    logic [IDX_W-1:0] miss_word = '0;
    logic miss_crit_first = 1'b0;
    logic miss_ready;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic [LINE_AW-1:0] mem_req_line;
    logic [IDX_W-1:0] mem_req_start;
    logic mem_req_wrap;
    logic mem_rsp_valid = 1'b0;
    logic [WORD_W-1:0] mem_rsp_data = '0;
    logic fill_we;
    logic [IDX_W-1:0] fill_idx;
    logic [WORD_W-1:0] fill_data;
    logic [LINE_WORDS-1:0] fill_mask;
    logic line_valid;
    logic crit_valid;
    logic [WORD_W-1:0] crit_data;
    logic acc_valid = 1'b0;
    logic [LINE_AW-1:0] acc_line = '0;
    logic [IDX_W-1:0] acc_word = '0;
    logic acc_hit;
    logic acc_stall;
    logic [WORD_W-1:0] acc_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    line_refill_ctrl #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINE_AW(LINE_AW)) u_line_refill_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_line(miss_line), .miss_word(miss_word),
        .miss_crit_first(miss_crit_first), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_line(mem_req_line), .mem_req_start(mem_req_start), .mem_req_wrap(mem_req_wrap),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_we(fill_we), .fill_idx(fill_idx), .fill_data(fill_data), .fill_mask(fill_mask),
        .line_valid(line_valid), .crit_valid(crit_valid), .crit_data(crit_data),
        .acc_valid(acc_valid), .acc_line(acc_line), .acc_word(acc_word),
        .acc_hit(acc_hit), .acc_stall(acc_stall), .acc_data(acc_data)
    );

    function automatic logic [WORD_W-1:0] word_val(input logic [LINE_AW-1:0] ln, input int idx);
        return {ln[15:0], 8'hA5, 5'b0, 3'(idx)};
    endfunction

    task automatic chk(input string req, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic refill(input logic [LINE_AW-1:0] ln, input int crit, input bit wrap,
                          input int lat, input bit gap);
        logic [LINE_WORDS-1:0] m;
        int k;
        int cyc;
        miss_valid = 1'b1; miss_line = ln; miss_word = 3'(crit); miss_crit_first = wrap;
        acc_valid = 1'b0;
        #1;
        chk("R8 ready when idle", 32'(miss_ready), 32'd1);
        tick;
        // second miss presented while busy must be ignored
        miss_line = ln ^ 26'h1; miss_word = 3'(crit + 1); miss_crit_first = !wrap;
        mem_req_ready = 1'b0;
        #1;
        chk("R8 ready low while busy", 32'(miss_ready), 32'd0);
        chk("R2 request valid", 32'(mem_req_valid), 32'd1);
        chk("R2 request line", 32'(mem_req_line), 32'(ln));
        chk("R2 request start", 32'(mem_req_start), wrap ? 32'(crit) : 32'd0);
        chk("R2 request wrap", 32'(mem_req_wrap), 32'(wrap));
        tick;
        #1;
        chk("R2 request held", 32'(mem_req_valid), 32'd1);
        chk("R2 start held", 32'(mem_req_start), wrap ? 32'(crit) : 32'd0);
        mem_req_ready = 1'b1;
        tick;
        mem_req_ready = 1'b0;
        m = '0; k = 0; cyc = 0;
        while (k < LINE_WORDS) begin
            bit rv;
            int ie;
            int w;
            bit avail;
            miss_valid = (k < 4);
            rv = (cyc >= lat) && (!gap || (cyc % 2 == 0));
            ie = wrap ? ((crit + k) % LINE_WORDS) : k;
            w = (cyc * 3 + crit) % LINE_WORDS;
            mem_rsp_valid = rv;
            mem_rsp_data = word_val(ln, ie);
            acc_valid = 1'b1; acc_line = ln; acc_word = 3'(w);
            #1;
            chk("R3 fill strobe", 32'(fill_we), 32'(rv));
            chk("R3 arrival mask", 32'(fill_mask), 32'(m));
            if (rv) begin
                chk(wrap ? "R3 wrapped index" : "R4 ascending index", 32'(fill_idx), 32'(ie));
                chk("R3 fill data", fill_data, word_val(ln, ie));
            end
            chk("R5 critical strobe", 32'(crit_valid), 32'(rv && ie == crit));
            if (rv && ie == crit) chk("R5 critical data", crit_data, word_val(ln, crit));
            avail = m[w] || (rv && ie == w);
            chk("R6 access hit", 32'(acc_hit), 32'(avail));
            chk("R6 access stall", 32'(acc_stall), 32'(!avail));
            if (avail) chk("R6 access data", acc_data, word_val(ln, w));
            chk("R7 line not yet valid", 32'(line_valid), 32'd0);
            chk("R8 busy ignores miss", 32'(miss_ready), 32'd0);
            if (rv) begin
                m[ie] = 1'b1;
                k++;
            end
            cyc++;
            tick;
        end
        mem_rsp_valid = 1'b0;
        miss_valid = 1'b0;
        acc_word = 3'(crit + 5);
        #1;
        chk("R7 line valid after last", 32'(line_valid), 32'd1);
        chk("R7 ready after last", 32'(miss_ready), 32'd1);
        chk("R3 mask full", 32'(fill_mask), 32'hFF);
        chk("R6 hit on completed line", 32'(acc_hit), 32'd1);
        chk("R6 completed line data", acc_data, word_val(ln, (crit + 5) % LINE_WORDS));
        acc_line = ln ^ 26'h2;
        #1;
        chk("R6 other line no hit", 32'(acc_hit), 32'd0);
        chk("R6 other line no stall", 32'(acc_stall), 32'd0);
        mem_rsp_valid = 1'b1;
        #1;
        chk("R8 response ignored when idle", 32'(fill_we), 32'd0);
        chk("R8 no critical when idle", 32'(crit_valid), 32'd0);
        tick;
        mem_rsp_valid = 1'b0;
        acc_valid = 1'b0;
        #1;
        chk("R8 idle response left line intact", 32'(fill_mask), 32'hFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        acc_valid = 1'b1; acc_line = '0; acc_word = '0;
        #1;
        chk("R1 ready after reset", 32'(miss_ready), 32'd1);
        chk("R1 no request after reset", 32'(mem_req_valid), 32'd0);
        chk("R1 line invalid after reset", 32'(line_valid), 32'd0);
        chk("R1 mask clear after reset", 32'(fill_mask), 32'd0);
        chk("R1 no hit after reset", 32'(acc_hit), 32'd0);
        chk("R1 no stall after reset", 32'(acc_stall), 32'd0);
        acc_valid = 1'b0;
        for (int li = 0; li < 2; li++) begin
            for (int md = 0; md < 2; md++) begin
                for (int c = 0; c < LINE_WORDS; c++) begin
                    refill(li == 0 ? 26'h12 : 26'h3ABC, c, md[0], c % 4, c[0] ^ md[0]);
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule